// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the fault bookkeeping of one CAN node. It holds a transmit error count and a receive error count. It moves the node between three states: error-active, error-passive and bus-off. Its inputs come from the protocol engine: pulses that report a transmit or receive error, and pulses that report a transmit or receive success.

In bus-off the node must not drive the bus. The unit leaves bus-off only after a recovery request. After that request it has to see 128 runs of eleven recessive bits on the sampled bus. A shorted or undriven bus has no differential voltage, so it samples as recessive without end. On such a bus the recovery completes after exactly 1408 bit times. If errors then go on, the node falls back into bus-off and the cycle repeats.

The unit also watches the sampled bit stream while a frame is in progress. It flags the sixth identical bit in a row as a stuffing violation, which the protocol engine can report as an error.

All pins are plain control and status lines. None of them carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `can_fault_guard`

## Requirements
- R1: Outside bus-off, `tx_err` adds 8 to `tec`. `tx_ok` subtracts 1 and stops at 0. When both pulse in the same cycle, only the error is applied.
- R2: Outside bus-off, `rx_err` adds 1 to `rec` and stops at 511. `rx_ok` subtracts 1 and stops at 0. When both pulse in the same cycle, only the error is applied.
- R3: Outside bus-off, `node_state` is 2'b01 (error-passive) when either counter is 128 or more. It is 2'b00 (error-active) when both counters are below 128. The state changes on the same edge as the counter that causes the change.
- R4: When `tec` would exceed 255, `node_state` becomes 2'b10 and `bus_off` goes to 1 on that edge. A `tec` value of exactly 255 leaves the node error-passive.
- R5: While in bus-off, all four event pulses are ignored and both counters hold their values.
- R6: A `recov_req` pulse during bus-off arms recovery. Counting starts in the next cycle. Each `bit_tick` with `bus_lvl`=1 (recessive) extends the current run. A tick with `bus_lvl`=0 (dominant) sets the run back to zero. Each completed run of 11 recessive bits counts as one occurrence. The edge that completes the 128th occurrence sets both counters to 0 and `node_state` to 2'b00. A `recov_req` pulse outside bus-off has no effect. Without a request, recessive bits never end bus-off.
- R7: While `in_frame`=1, the sixth consecutive `bit_tick` sample at the same level makes `stuff_err` high for one cycle, on that tick's edge. The seventh and later identical samples do not repeat the pulse. A change of level restarts the count, and so does `in_frame`=0.
- R8: A synchronous reset (`rst_n`=0) gives `tec`=0, `rec`=0, `node_state`=2'b00, `bus_off`=0 and `stuff_err`=0.
- R9: After recovery the node can reach bus-off again through further transmit errors.
- R10: Every output is a register. Each output reflects the inputs seen at the rising edge that ends the cycle in which they were presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| bus_lvl | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| in_frame | input | 1 | High while a frame is in progress; enables the stuffing check |
| tx_err | input | 1 | Transmit error event pulse |
| tx_ok | input | 1 | Successful transmission pulse |
| rx_err | input | 1 | Receive error event pulse |
| rx_ok | input | 1 | Successful reception pulse |
| recov_req | input | 1 | Request to start bus-off recovery |
| tec | output | 9 | Transmit error counter |
| rec | output | 9 | Receive error counter |
| node_state | output | 2 | 00 error-active, 01 error-passive, 10 bus-off |
| bus_off | output | 1 | High while the node must not drive the bus |
| stuff_err | output | 1 | One-cycle pulse on a stuffing violation |

## Verification
Each result is due at the first rising edge after the cycle in which its stimulus is presented. This holds for counter steps, state changes, stuff pulses and the end of recovery alike. The bench drives one stimulus at each falling edge and queues the expected outputs for it. The comparison runs one time unit after the following rising edge, so it always reads the value from exactly one edge later. Recovery is checked bit by bit, and the only cycle allowed to leave bus-off is the one that carries the 1408th counted recessive bit.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    NODE_ACTIVE  = 2'b00,
    NODE_PASSIVE = 2'b01,
    NODE_OFF     = 2'b10
  } node_state_e;
endpackage

// File: rtl/can_fc_errcnt.sv
// Saturating error counter: an error adds UP_STEP, a success subtracts one.
module can_fc_errcnt #(
  parameter int CNT_W   = 9,
  parameter int UP_STEP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             clear,
  input  logic             up,
  input  logic             down,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] STEP = CNT_W'(UP_STEP);

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (!freeze) begin
      if (up) begin
        cnt_d = (cnt_q > CMAX - STEP) ? CMAX : cnt_q + STEP;
      end else if (down && cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/can_fc_stuffdet.sv
// Flags the RUN-th consecutive identical sample while enabled.
module can_fc_stuffdet #(
  parameter int RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic lvl,
  output logic hit
);
  localparam int LEN_W = $clog2(RUN + 1);
  localparam logic [LEN_W-1:0] LAST_LEN = LEN_W'(RUN - 1);
  localparam logic [LEN_W-1:0] SAT_LEN  = LEN_W'(RUN);

  logic [LEN_W-1:0] len_q;
  logic             last_q;
  logic             same;

  assign same = (len_q != '0) && (lvl == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      len_q  <= '0;
      last_q <= 1'b1;
      hit    <= 1'b0;
    end else if (tick) begin
      last_q <= lvl;
      hit    <= same && (len_q == LAST_LEN);
      if (!same)                len_q <= LEN_W'(1);
      else if (len_q < SAT_LEN) len_q <= len_q + 1'b1;
    end else begin
      hit <= 1'b0;
    end
  end
endmodule

// File: rtl/can_fc_recovery.sv
// Counts RUNS completed runs of RUN_BITS recessive samples once armed.
module can_fc_recovery #(
  parameter int RUN_BITS = 11,
  parameter int RUNS     = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic off,
  input  logic req,
  input  logic tick,
  input  logic lvl,
  output logic done
);
  localparam int RB_W = $clog2(RUN_BITS);
  localparam int OC_W = $clog2(RUNS);
  localparam logic [RB_W-1:0] RB_LAST = RB_W'(RUN_BITS - 1);
  localparam logic [OC_W-1:0] OC_LAST = OC_W'(RUNS - 1);

  logic            armed_q;
  logic [RB_W-1:0] run_q;
  logic [OC_W-1:0] occ_q;
  logic            run_end;

  assign run_end = off && armed_q && tick && lvl && (run_q == RB_LAST);
  assign done    = run_end && (occ_q == OC_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !off) begin
      armed_q <= 1'b0;
      run_q   <= '0;
      occ_q   <= '0;
    end else begin
      if (req) armed_q <= 1'b1;
      if (armed_q && tick) begin
        if (!lvl) begin
          run_q <= '0;
        end else if (run_end) begin
          run_q <= '0;
          occ_q <= occ_q + 1'b1;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/can_fault_guard.sv
module can_fault_guard #(
  parameter int CNT_W        = 9,
  parameter int TX_STEP      = 8,
  parameter int OFF_LIMIT    = 255,
  parameter int PASSIVE_TH   = 128,
  parameter int STUFF_RUN    = 6,
  parameter int IDLE_RUN     = 11,
  parameter int IDLE_RUNS    = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             bus_lvl,
  input  logic             in_frame,
  input  logic             tx_err,
  input  logic             tx_ok,
  input  logic             rx_err,
  input  logic             rx_ok,
  input  logic             recov_req,
  output logic [CNT_W-1:0] tec,
  output logic [CNT_W-1:0] rec,
  output logic [1:0]       node_state,
  output logic             bus_off,
  output logic             stuff_err
);
  import can_fc_pkg::*;

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(OFF_LIMIT);
  localparam logic [CNT_W-1:0] PASS_V  = CNT_W'(PASSIVE_TH);

  node_state_e      state_q, state_d;
  logic             frozen, recovered;
  logic [CNT_W-1:0] tec_d, rec_d;
  logic [1:0]       ups, downs;
  logic [CNT_W-1:0] cnt_q [2];
  logic [CNT_W-1:0] cnt_d [2];

  assign frozen = (state_q == NODE_OFF);
  assign ups    = {rx_err, tx_err};
  assign downs  = {rx_ok, tx_ok};

  // index 0: transmit counter, index 1: receive counter
  for (genvar i = 0; i < 2; i++) begin : g_cnt
    can_fc_errcnt #(
      .CNT_W  (CNT_W),
      .UP_STEP((i == 0) ? TX_STEP : 1)
    ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .freeze(frozen),
      .clear (recovered),
      .up    (ups[i]),
      .down  (downs[i]),
      .cnt_q (cnt_q[i]),
      .cnt_d (cnt_d[i])
    );
  end

  assign tec   = cnt_q[0];
  assign rec   = cnt_q[1];
  assign tec_d = cnt_d[0];
  assign rec_d = cnt_d[1];

  can_fc_recovery #(
    .RUN_BITS(IDLE_RUN),
    .RUNS    (IDLE_RUNS)
  ) u_recov (
    .clk  (clk),
    .rst_n(rst_n),
    .off  (frozen),
    .req  (recov_req),
    .tick (bit_tick),
    .lvl  (bus_lvl),
    .done (recovered)
  );

  can_fc_stuffdet #(
    .RUN(STUFF_RUN)
  ) u_stuff (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (in_frame),
    .tick (bit_tick),
    .lvl  (bus_lvl),
    .hit  (stuff_err)
  );

  always_comb begin
    state_d = state_q;
    if (state_q == NODE_OFF) begin
      if (recovered) state_d = NODE_ACTIVE;
    end else if (tec_d > LIMIT_V) begin
      state_d = NODE_OFF;
    end else if (tec_d >= PASS_V || rec_d >= PASS_V) begin
      state_d = NODE_PASSIVE;
    end else begin
      state_d = NODE_ACTIVE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= NODE_ACTIVE;
    else        state_q <= state_d;
  end

  assign node_state = state_q;
  assign bus_off    = frozen;
endmodule

// File: rtl/can_fc_checker.sv
module can_fc_checker #(
  parameter int CNT_W      = 9,
  parameter int TX_STEP    = 8,
  parameter int OFF_LIMIT  = 255,
  parameter int PASSIVE_TH = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic             in_frame,
  input logic             tx_err,
  input logic [CNT_W-1:0] tec,
  input logic [CNT_W-1:0] rec,
  input logic [1:0]       node_state,
  input logic             bus_off,
  input logic             stuff_err
);
  localparam logic [CNT_W:0]   LIM_W  = (CNT_W+1)'(OFF_LIMIT);
  localparam logic [CNT_W:0]   STEP_W = (CNT_W+1)'(TX_STEP);
  localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASSIVE_TH);

  assert_tx_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_off && tx_err && ({1'b0, tec} + STEP_W <= LIM_W))
      |=> ({1'b0, tec} == {1'b0, $past(tec)} + STEP_W));

  assert_passive_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_off |-> ((node_state == 2'b01) == (tec >= PASS_V || rec >= PASS_V)));

  assert_enter_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_off && tx_err && ({1'b0, tec} + STEP_W > LIM_W)) |=> bus_off);

  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |=> (bus_off ? ($stable(tec) && $stable(rec))
                         : (tec == '0 && rec == '0 && node_state == 2'b00)));

  assert_stuff_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |-> ($past(bit_tick) && $past(in_frame)));

  assert_state_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    node_state != 2'b11);
endmodule

bind can_fault_guard can_fc_checker #(
  .CNT_W     (CNT_W),
  .TX_STEP   (TX_STEP),
  .OFF_LIMIT (OFF_LIMIT),
  .PASSIVE_TH(PASSIVE_TH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_tick  (bit_tick),
  .in_frame  (in_frame),
  .tx_err    (tx_err),
  .tec       (tec),
  .rec       (rec),
  .node_state(node_state),
  .bus_off   (bus_off),
  .stuff_err (stuff_err)
);

// File: tb/sim_can_fault_guard.sv
`timescale 1ns/1ps
module sim_can_fault_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 0, bus_lvl = 1, in_frame = 0;
  logic tx_err = 0, tx_ok = 0, rx_err = 0, rx_ok = 0, recov_req = 0;
  logic [8:0] tec, rec;
  logic [1:0] node_state;
  logic bus_off, stuff_err;

  always #2 clk = ~clk;

  can_fault_guard u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bus_lvl(bus_lvl),
    .in_frame(in_frame), .tx_err(tx_err), .tx_ok(tx_ok), .rx_err(rx_err),
    .rx_ok(rx_ok), .recov_req(recov_req), .tec(tec), .rec(rec),
    .node_state(node_state), .bus_off(bus_off), .stuff_err(stuff_err)
  );

  typedef struct {
    int    tec, rec, st, boff, stf;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  // independent model state, derived from the requirements
  int m_tec = 0, m_rec = 0, m_st = 0;
  int m_armed = 0, m_run = 0, m_occ = 0;
  int m_slen = 0, m_last = 1;

  task automatic report(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: present one cycle of stimulus at the falling edge, queue the result
  task automatic step(bit tk, bit lv, bit fr, bit te, bit to, bit re, bit ro,
                      bit rq, string tag);
    exp_t e;
    int stf, done;
    @(negedge clk);
    bit_tick = tk; bus_lvl = lv; in_frame = fr;
    tx_err = te; tx_ok = to; rx_err = re; rx_ok = ro; recov_req = rq;
    // R7 stuffing model
    stf = 0;
    if (!fr) m_slen = 0;
    else if (tk) begin
      if (m_slen != 0 && int'(lv) == m_last) begin
        stf = (m_slen == 5);
        if (m_slen < 6) m_slen++;
      end else m_slen = 1;
      m_last = lv;
    end
    if (m_st == 2) begin
      // R5 frozen, R6 recovery
      done = 0;
      if (m_armed != 0 && tk) begin
        if (!lv) m_run = 0;
        else if (m_run == 10) begin
          m_run = 0;
          if (m_occ == 127) done = 1; else m_occ++;
        end else m_run++;
      end
      if (rq) m_armed = 1;
      if (done != 0) begin
        m_tec = 0; m_rec = 0; m_st = 0; m_armed = 0; m_run = 0; m_occ = 0;
      end
    end else begin
      // R1 R2 counters, R3 R4 states
      if (te) m_tec += 8;
      else if (to && m_tec > 0) m_tec--;
      if (m_tec > 511) m_tec = 511;
      if (re) m_rec = (m_rec < 511) ? m_rec + 1 : 511;
      else if (ro && m_rec > 0) m_rec--;
      if (m_tec > 255) begin
        m_st = 2; m_armed = 0; m_run = 0; m_occ = 0;
      end else m_st = (m_tec >= 128 || m_rec >= 128) ? 1 : 0;
    end
    e.tec = m_tec; e.rec = m_rec; e.st = m_st;
    e.boff = (m_st == 2); e.stf = stf; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 1, 0, 0, 0, 0, 0, 0, "R10");
  endtask

  // monitor: R10 each result is read one time unit after the following edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        report(e.tag, "tec", int'(tec), e.tec);
        report(e.tag, "rec", int'(rec), e.rec);
        report(e.tag, "node_state", int'(node_state), e.st);
        report(e.tag, "bus_off", int'(bus_off), e.boff);
        report(e.tag, "stuff_err", int'(stuff_err), e.stf);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    report("R8", "tec", int'(tec), 0);
    report("R8", "rec", int'(rec), 0);
    report("R8", "node_state", int'(node_state), 0);
    report("R8", "bus_off", int'(bus_off), 0);
    report("R8", "stuff_err", int'(stuff_err), 0);

    // R1 transmit counter steps, saturation and priority
    for (int i = 0; i < 3; i++) step(0, 1, 0, 1, 0, 0, 0, 0, "R1");
    step(0, 1, 0, 0, 1, 0, 0, 0, "R1");
    step(0, 1, 0, 1, 1, 0, 0, 0, "R1");
    for (int i = 0; i < 33; i++) step(0, 1, 0, 0, 1, 0, 0, 0, "R1");

    // R2 receive counter and floor at zero
    step(0, 1, 0, 0, 0, 1, 0, 0, "R2");
    step(0, 1, 0, 0, 0, 1, 1, 0, "R2");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0, 1, 0, "R2");

    // R3 passive threshold through the receive counter
    for (int i = 0; i < 128; i++) step(0, 1, 0, 0, 0, 1, 0, 0, "R3");
    step(0, 1, 0, 0, 0, 0, 1, 0, "R3");
    step(0, 1, 0, 0, 0, 1, 0, 0, "R3");
    for (int i = 0; i < 130; i++) step(0, 1, 0, 0, 0, 0, 1, 0, "R3");

    // R7 stuffing: six dominant, a seventh, then alternating, then frame end
    for (int i = 0; i < 7; i++) step(1, 0, 1, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 1, 0, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 4; i++) step(1, i % 2, 1, 0, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 5; i++) step(1, 1, 1, 0, 0, 0, 0, 0, "R7");
    step(1, 1, 0, 0, 0, 0, 0, 0, "R7");
    step(1, 1, 1, 0, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 6; i++) step(1, 1, 1, 0, 0, 0, 0, 0, "R7");

    // R6 a request while not in bus-off must not arm recovery
    step(0, 1, 0, 0, 0, 0, 0, 1, "R6");

    // R4 tec 255 stays passive, 263 enters bus-off
    for (int i = 0; i < 31; i++) step(0, 1, 0, 1, 0, 0, 0, 0, "R4");
    step(0, 1, 0, 0, 1, 0, 0, 0, "R4");
    step(0, 1, 0, 1, 0, 0, 0, 0, "R4");
    step(0, 1, 0, 1, 0, 0, 0, 0, "R4");

    // R5 events ignored in bus-off
    step(0, 1, 0, 0, 1, 1, 0, 0, "R5");
    step(0, 1, 0, 1, 0, 0, 1, 0, "R5");

    // R6 no request: a long recessive stream keeps bus-off
    for (int i = 0; i < 1500; i++) step(1, 1, 0, 0, 0, 0, 0, 0, "R6");

    // R6 shorted bus recovery with a dominant break and tick gaps
    step(0, 1, 0, 0, 0, 0, 0, 1, "R6");
    for (int i = 0; i < 10; i++) step(1, 1, 0, 0, 0, 0, 0, 0, "R6");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R6");
    for (int i = 0; i < 1408; i++) begin
      if (i % 100 == 50) step(0, 0, 0, 0, 0, 0, 0, 0, "R6");
      step(1, 1, 0, 0, 0, 0, 0, 0, "R6");
    end
    idle(2);

    // R9 errors resume: back to bus-off, then a second recovery
    for (int i = 0; i < 32; i++) step(0, 1, 0, 1, 0, 0, 0, 0, "R9");
    step(0, 1, 0, 0, 0, 0, 0, 1, "R9");
    for (int i = 0; i < 1409; i++) step(1, 1, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 1, 0, 1, 0, 0, 0, 0, "R9");
    idle(3);

    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule